// File: doc/BRIEF.md
# Eight-Pin General-Purpose Port with Change Interrupt

This block is the port core of a small I/O expander. A host reaches it over a plain register bus. Each access carries a two-bit register select, a write strobe with its data, and a read strobe. Read data comes back on the next cycle. Each of the eight pins is set on its own as a driven output or as an input. The pin side gives a value and an output enable per pin, and takes a raw sampled level per pin.

Pin levels pass through a two-flop synchroniser. A read of the input register captures the synchronised levels into a capture register and returns them, each bit inverted where the polarity register says so. The interrupt compares the live synchronised level of every input pin against the capture register. It is active while any input pin differs from its captured bit. It goes away when the pin returns, or when the input register is read and the capture is refreshed. Switching a pin from output to input while its level disagrees with the capture raises the interrupt, and this is intended. The interrupt line is presented as an open-drain pair: an active-low level and an enable.

Top module: `gpx_port`

## Requirements
- R1: While and after synchronous reset, every pin is an input (`pin_oe` = 0x00), the output register is 0xFF, the polarity register is 0x00, and the interrupt is idle.
- R2: Configuration register (select 3): bit value 1 makes the pin an input with `pin_oe` low, and 0 makes it a driven output with `pin_oe` high. A write is visible on `pin_oe` on the cycle after the strobe.
- R3: `pin_out` carries the output register (select 1), and a write to it is visible on the cycle after the strobe.
- R4: A read strobe returns the selected register on `rd_data` on the next cycle: select 1 is the output register, 2 is polarity, 3 is configuration. `rd_data` holds its value until the next read.
- R5: A read with select 0 loads the capture register with the synchronised pin levels and returns those levels XORed with the polarity register. A pin level reaches the synchroniser output two clock edges after it is applied.
- R6: A write with select 0 changes no register: output drive, enables, read-back values and capture stay as they were.
- R7: The interrupt becomes active on the third rising edge after an input-configured pin takes a level that differs from its captured bit. Pins configured as outputs never cause it.
- R8: The interrupt becomes inactive once every input pin again matches its captured bit, with the same latency as R7.
- R9: A capture read clears the interrupt at the edge that samples the read strobe.
- R10: Changing a pin from output to input while its level differs from the captured bit raises the interrupt on the second edge after the configuration write.
- R11: The interrupt output is open-drain: when active, `irq_n` = 0 and `irq_oe` = 1; when idle, `irq_n` = 1 and `irq_oe` = 0.
- R12: On the first cycle after reset the capture register loads the synchronised pins, so steady pins leave the interrupt idle and a first read returns them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reg_sel | input | 2 | Register select: 0 input, 1 output, 2 polarity, 3 configuration |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 8 | Read data, valid the cycle after `rd_en` |
| pin_in | input | 8 | Raw pin levels |
| pin_out | output | 8 | Per-pin drive value |
| pin_oe | output | 8 | Per-pin drive enable |
| irq_n | output | 1 | Interrupt level, active low |
| irq_oe | output | 1 | Interrupt driver enable (open-drain pull-down) |

## Verification
Assertions check, on every cycle, several one-step cause-and-effect relations. Writes to the output and configuration registers reach the pins one cycle later. A select-0 write leaves every register unchanged. A capture read clears the interrupt, and the interrupt is only ever active when some pin was configured as input. Other behaviour only the bench's scenarios can show. These are the three-edge latency from a pin change to the interrupt, that output pins are masked, that the interrupt clears when a pin returns, that polarity alters only the returned value and not the capture, and that an output-to-input switch raises the interrupt. The reference model is compared with the block on every cycle to cover them.

// File: rtl/gpx_pkg.sv
package gpx_pkg;

    localparam int unsigned SEL_W = 2;

    typedef enum logic [SEL_W-1:0] {
        SEL_IN  = 2'd0,
        SEL_OUT = 2'd1,
        SEL_POL = 2'd2,
        SEL_CFG = 2'd3
    } gpx_sel_e;

    typedef struct packed {
        logic     wr;
        logic     rd;
        gpx_sel_e sel;
    } gpx_cmd_t;

    function automatic logic sel_writable(gpx_sel_e s);
        return s != SEL_IN;
    endfunction

    function automatic logic is_capture(gpx_cmd_t c);
        return c.rd && (c.sel == SEL_IN);
    endfunction

endpackage

// File: rtl/gpx_sync.sv
module gpx_sync #(
    parameter int unsigned WIDTH = 8
) (
    input  logic             clk,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        logic meta_q;
        logic sync_q;
        always_ff @(posedge clk) begin
            meta_q <= d[i];
            sync_q <= meta_q;
        end
        assign q[i] = sync_q;
    end
endmodule

// File: rtl/gpx_regs.sv
module gpx_regs
    import gpx_pkg::*;
#(
    parameter int unsigned WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  gpx_cmd_t         cmd,
    input  logic [WIDTH-1:0] wr_data,
    input  logic [WIDTH-1:0] pin_sync,
    output logic [WIDTH-1:0] out_q,
    output logic [WIDTH-1:0] cfg_q,
    output logic [WIDTH-1:0] cap_q,
    output logic [WIDTH-1:0] rd_data,
    output logic             cap_take
);
    logic [WIDTH-1:0] pol_q;
    logic             prime_q;
    logic [WIDTH-1:0] rd_mux;
    logic             wr_ok;

    assign cap_take = prime_q || is_capture(cmd);
    assign wr_ok    = cmd.wr && sel_writable(cmd.sel);

    always_comb begin
        unique case (cmd.sel)
            SEL_IN:  rd_mux = pin_sync ^ pol_q;
            SEL_OUT: rd_mux = out_q;
            SEL_POL: rd_mux = pol_q;
            default: rd_mux = cfg_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_q   <= '1;
            pol_q   <= '0;
            cfg_q   <= '1;
            cap_q   <= '0;
            rd_data <= '0;
            prime_q <= 1'b1;
        end else begin
            prime_q <= 1'b0;
            if (cap_take) cap_q <= pin_sync;
            if (cmd.rd) rd_data <= rd_mux;
            if (wr_ok) begin
                unique case (cmd.sel)
                    SEL_OUT: out_q <= wr_data;
                    SEL_POL: pol_q <= wr_data;
                    default: cfg_q <= wr_data;
                endcase
            end
        end
    end

    // R6: a select-0 write leaves every register untouched
    a_r6_in_write_ignored: assert property (@(posedge clk) disable iff (rst)
        (cmd.wr && cmd.sel == SEL_IN && !cmd.rd && !prime_q)
        |=> ($stable(out_q) && $stable(pol_q) && $stable(cfg_q) && $stable(cap_q)));

    // R3: output register takes the written byte
    a_r3_out_write: assert property (@(posedge clk) disable iff (rst)
        (cmd.wr && cmd.sel == SEL_OUT) |=> (out_q == $past(wr_data)));

    // R4: read data holds between reads
    a_r4_rd_hold: assert property (@(posedge clk) disable iff (rst)
        !cmd.rd |=> $stable(rd_data));
endmodule

// File: rtl/gpx_irq.sv
module gpx_irq #(
    parameter int unsigned WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] pin_sync,
    input  logic [WIDTH-1:0] cap_q,
    input  logic [WIDTH-1:0] cfg_q,
    input  logic             cap_take,
    output logic             irq_q
);
    logic [WIDTH-1:0] diff;
    logic             mismatch;

    assign diff     = (pin_sync ^ cap_q) & cfg_q;
    assign mismatch = |diff;

    always_ff @(posedge clk) begin
        if (rst) irq_q <= 1'b0;
        else     irq_q <= mismatch && !cap_take;
    end

    // R9: a capture clears the interrupt at once
    a_r9_read_clears: assert property (@(posedge clk) disable iff (rst)
        cap_take |=> !irq_q);

    // R7: only input-configured pins can raise it
    a_r7_needs_input: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_q) |-> ($past(cfg_q) != '0));
endmodule

// File: rtl/gpx_port.sv
module gpx_port
    import gpx_pkg::*;
#(
    parameter int unsigned WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [1:0]       reg_sel,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             rd_en,
    output logic [WIDTH-1:0] rd_data,
    input  logic [WIDTH-1:0] pin_in,
    output logic [WIDTH-1:0] pin_out,
    output logic [WIDTH-1:0] pin_oe,
    output logic             irq_n,
    output logic             irq_oe
);
    gpx_cmd_t         cmd;
    logic [WIDTH-1:0] pin_sync;
    logic [WIDTH-1:0] out_q;
    logic [WIDTH-1:0] cfg_q;
    logic [WIDTH-1:0] cap_q;
    logic             cap_take;
    logic             irq_q;

    assign cmd.wr  = wr_en;
    assign cmd.rd  = rd_en;
    assign cmd.sel = gpx_sel_e'(reg_sel);

    gpx_sync #(.WIDTH(WIDTH)) u_sync (
        .clk (clk),
        .d   (pin_in),
        .q   (pin_sync)
    );

    gpx_regs #(.WIDTH(WIDTH)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .cmd      (cmd),
        .wr_data  (wr_data),
        .pin_sync (pin_sync),
        .out_q    (out_q),
        .cfg_q    (cfg_q),
        .cap_q    (cap_q),
        .rd_data  (rd_data),
        .cap_take (cap_take)
    );

    gpx_irq #(.WIDTH(WIDTH)) u_irq (
        .clk      (clk),
        .rst      (rst),
        .pin_sync (pin_sync),
        .cap_q    (cap_q),
        .cfg_q    (cfg_q),
        .cap_take (cap_take),
        .irq_q    (irq_q)
    );

    assign pin_out = out_q;
    assign pin_oe  = ~cfg_q;
    assign irq_n   = ~irq_q;
    assign irq_oe  = irq_q;

    // R2: a configuration write reaches the pin enables next cycle
    a_r2_cfg_to_oe: assert property (@(posedge clk) disable iff (rst)
        (wr_en && reg_sel == 2'd3) |=> (pin_oe == ~$past(wr_data)));

    // R1: reset leaves every pin undriven
    a_r1_reset_inputs: assert property (@(posedge clk)
        $past(rst) |-> (pin_oe == '0 && pin_out == '1));
endmodule

// File: tb/sim_gpx_port.sv
module sim_gpx_port;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] reg_sel = 2'd0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       rd_en = 1'b0;
    logic [7:0] rd_data;
    logic [7:0] pin_in = 8'hA5;
    logic [7:0] pin_out;
    logic [7:0] pin_oe;
    logic       irq_n;
    logic       irq_oe;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    always #5 clk = ~clk;

    gpx_port u0 (
        .clk(clk), .rst(rst), .reg_sel(reg_sel), .wr_en(wr_en),
        .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
        .irq_n(irq_n), .irq_oe(irq_oe)
    );

    // behavioural reference
    int         m_out = 255, m_pol = 0, m_cfg = 255, m_cap = 0, m_rd = 0;
    bit         m_irq = 0, m_prime = 1;
    int         hist[$];

    always @(posedge clk) begin
        int  seen, mism;
        bit  capt, old_prime;
        seen = (hist.size() > 1) ? hist[1] : int'(pin_in);
        hist.push_front(int'(pin_in));
        if (hist.size() > 4) void'(hist.pop_back());
        cycles++;
        if (rst) begin
            m_out = 255; m_pol = 0; m_cfg = 255; m_cap = 0; m_rd = 0;
            m_irq = 0; m_prime = 1;
        end else begin
            mism      = (seen ^ m_cap) & m_cfg;
            capt      = rd_en && (reg_sel == 2'd0);
            old_prime = m_prime;
            m_irq     = (mism != 0) && !old_prime && !capt;
            if (rd_en) begin
                if (reg_sel == 2'd0)      m_rd = seen ^ m_pol;
                else if (reg_sel == 2'd1) m_rd = m_out;
                else if (reg_sel == 2'd2) m_rd = m_pol;
                else                      m_rd = m_cfg;
            end
            if (old_prime || capt) m_cap = seen;
            m_prime = 0;
            if (wr_en) begin
                if (reg_sel == 2'd1)      m_out = int'(wr_data);
                else if (reg_sel == 2'd2) m_pol = int'(wr_data);
                else if (reg_sel == 2'd3) m_cfg = int'(wr_data);
            end
        end
    end

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // every-cycle comparison against the model
    always @(negedge clk) begin
        if (!rst) begin
            chk("R2 pin_oe", int'(pin_oe), (~m_cfg) & 255);
            chk("R3 pin_out", int'(pin_out), m_out);
            chk("R4 rd_data", int'(rd_data), m_rd);
            chk("R7 irq_n", int'(irq_n), m_irq ? 0 : 1);
            chk("R11 irq_oe", int'(irq_oe), m_irq ? 1 : 0);
        end
    end

    task automatic idle(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wr(int sel, int val);
        @(negedge clk);
        reg_sel = 2'(sel); wr_data = 8'(val); wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(int sel);
        @(negedge clk);
        reg_sel = 2'(sel); rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic finish_up();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        wait (cycles > 20000);
        checks++; fails++;
        $display("FAIL watchdog actual=%0d expected=<20000 cycles", cycles);
        finish_up();
    end

    initial begin
        idle(4);
        chk("R1 oe in reset", int'(pin_oe), 0);
        chk("R1 out in reset", int'(pin_out), 255);
        chk("R1 irq in reset", int'(irq_n), 1);
        rst = 1'b0;
        idle(5);
        chk("R12 no irq after reset", int'(irq_n), 1);
        rd(0);
        chk("R12 first capture", int'(rd_data), 'hA5);
        rd(2);
        chk("R1 polarity default", int'(rd_data), 0);
        rd(3);
        chk("R4 cfg readback", int'(rd_data), 255);
        wr(2, 'h0F);
        rd(0);
        chk("R5 inverted read", int'(rd_data), 'hAA);
        wr(0, 'h00);
        wr(1, 'h3C);
        wr(3, 'hF0);
        rd(0);
        chk("R6 capture kept", int'(rd_data), 'hAA);
        rd(1);
        chk("R6 out after ignored write", int'(rd_data), 'h3C);
        chk("R2 oe low nibble", int'(pin_oe), 'h0F);
        chk("R3 drive", int'(pin_out), 'h3C);
        @(negedge clk); pin_in = 8'hA4;         // output pin toggles
        idle(5);
        chk("R7 output pin masked", int'(irq_n), 1);
        @(negedge clk); pin_in = 8'h24;         // input pin 7 changes
        idle(2);
        chk("R7 not yet", int'(irq_n), 1);
        idle(1);
        chk("R7 raised third edge", int'(irq_n), 0);
        chk("R11 drive enable", int'(irq_oe), 1);
        @(negedge clk); pin_in = 8'hA4;
        idle(3);
        chk("R8 cleared on return", int'(irq_n), 1);
        chk("R11 released", int'(irq_oe), 0);
        @(negedge clk); pin_in = 8'hE4;
        idle(4);
        chk("R7 raised bit6", int'(irq_n), 0);
        rd(0);
        chk("R9 cleared by read", int'(irq_n), 1);
        chk("R5 read value", int'(rd_data), 'hEB);
        @(negedge clk); pin_in = 8'hE6;         // output pin 1 differs
        idle(4);
        chk("R10 masked while output", int'(irq_n), 1);
        wr(3, 'hFF);
        chk("R10 not on first edge", int'(irq_n), 1);
        idle(1);
        chk("R10 switch raises", int'(irq_n), 0);
        rd(0);
        chk("R9 read clears again", int'(irq_n), 1);
        idle(3);
        finish_up();
    end
endmodule